// File: doc/BRIEF.md
# Processor-Side Memory and Peripheral Router

This block sits between a processor's single-word load/store port and four targets: main RAM, an interrupt controller, a serial port and a block-storage device. For every accepted request it raises exactly one select strobe and presents the local offset for that target. It then returns that target's read data one cycle later on a response channel. Low addresses go straight to RAM. The top address nibble opens a peripheral window that is carved into 1 MiB slots.

The block also owns the interrupt controller's source vector for the two device interrupts. The level of a device's interrupt line is copied into its source bit only when that device is accessed. After any peripheral access, a one-cycle evaluate pulse tells the controller to recompute its outputs.

Both request and response are valid/ready channels. Only one response can be outstanding. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` is high exactly when no response is waiting or the waiting response is consumed in the same cycle (`rsp_ready`). A response that is not consumed stays on the port with the same data and flag until it is taken. A read target must answer combinationally in the acceptance cycle, because its select strobe and offset are valid only in that cycle.

Top module: `mem_io_router`

## Requirements
- R1: An address strictly below `RAM_BYTES` (default 0x0400_0000) selects RAM, and `ram_addr` equals the request address unchanged. RAM takes priority over every other decode.
- R2: If address bits [31:28] are 0xF and bits [27:20] are 0x00 or 0x02, the interrupt controller is selected. Its offset `intc_off` is address bits [25:0].
- R3: In the same window, slot 0x40 selects the serial port and slot 0x42 selects the block device. Each receives address bits [19:0] as its offset.
- R4: Any other address is a decode error. This covers unmapped slots in the window and addresses outside both RAM and the window. A decode error raises no select strobe, and its response carries `rsp_err`=1 with read data 0.
- R5: `req_ready` = !`rsp_valid` || `rsp_ready`. Select strobes appear only in an accepting cycle, and at most one of them at a time.
- R6: In the cycle after acceptance, `rsp_valid` is 1. For a read, `rsp_rdata` holds the selected target's read data as it was in the acceptance cycle. For a write it is 0, and `rsp_err` is 0 for mapped targets.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, the response (valid, data, flag) holds unchanged. `rsp_valid` falls after a cycle with `rsp_ready`=1 and no new acceptance.
- R8: Source bit 1 of `intc_src` takes the `uart_irq` level sampled in the cycle a serial-port access is accepted. It keeps its value across all other cycles.
- R9: Source bit 2 of `intc_src` behaves the same way for `blk_irq` and block-device accesses. All other source bits read 0.
- R10: `intc_eval` is high for exactly the one cycle after each accepted access to the interrupt controller, serial port or block device. It stays low after RAM accesses and decode errors.
- R11: After reset, `rsp_valid`, `intc_src` and `intc_eval` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Load data (0 for stores and errors) |
| rsp_err | output | 1 | Decode error flag of the response |
| wr_en | output | 1 | Store qualifier shared by all targets |
| wr_data | output | 32 | Store data shared by all targets |
| ram_sel | output | 1 | RAM select strobe |
| ram_addr | output | 32 | RAM address |
| ram_rdata | input | 32 | RAM read data |
| intc_sel | output | 1 | Interrupt controller select strobe |
| intc_off | output | 26 | Interrupt controller offset |
| intc_rdata | input | 32 | Interrupt controller read data |
| intc_src | output | 8 | Interrupt source vector |
| intc_eval | output | 1 | Re-evaluate pulse to the controller |
| uart_sel | output | 1 | Serial port select strobe |
| uart_off | output | 20 | Serial port offset |
| uart_rdata | input | 32 | Serial port read data |
| uart_irq | input | 1 | Serial port interrupt level |
| blk_sel | output | 1 | Block device select strobe |
| blk_off | output | 20 | Block device offset |
| blk_rdata | input | 32 | Block device read data |
| blk_irq | input | 1 | Block device interrupt level |

## Verification
The hardest case to reach from the ports combines three conditions at once: a response is stalled, a new request is waiting behind it, and the device interrupt levels change while that request waits. The source bit must take the level from the cycle of acceptance, not the level from the cycle the request was raised. To get there, the bench drives `rsp_ready` from a shift-register pattern and issues requests back to back over a mixed address set. It also flips both interrupt lines in the middle of a request. A behavioural model, advanced on every clock, predicts the strobes, offsets, response and source vector.

// File: rtl/mmdec_pkg.sv
package mmdec_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned SLOT_W = 8;
  localparam int unsigned N_TGT  = 5;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_RAM  = 3'd1,
    TGT_INTC = 3'd2,
    TGT_UART = 3'd3,
    TGT_BLK  = 3'd4
  } tgt_e;
endpackage

// File: rtl/mmdec_slot_decode.sv
module mmdec_slot_decode
  import mmdec_pkg::*;
#(
  parameter logic [ADDR_W:0]   RAM_BYTES   = 33'h0_0400_0000,
  parameter logic [TAG_W-1:0]  WIN_TAG     = 4'hF,
  parameter logic [SLOT_W-1:0] INTC_SLOT_A = 8'h00,
  parameter logic [SLOT_W-1:0] INTC_SLOT_B = 8'h02,
  parameter logic [SLOT_W-1:0] UART_SLOT   = 8'h40,
  parameter logic [SLOT_W-1:0] BLK_SLOT    = 8'h42
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  localparam int unsigned TAG_LSB  = ADDR_W - TAG_W;
  localparam int unsigned SLOT_LSB = TAG_LSB - SLOT_W;

  logic              in_ram;
  logic              in_win;
  logic [SLOT_W-1:0] slot;

  // stage one: RAM range, then the window tag
  assign in_ram = ({1'b0, addr} < RAM_BYTES);
  assign in_win = (addr[ADDR_W-1:TAG_LSB] == WIN_TAG);
  // stage two: slot inside the window
  assign slot   = addr[TAG_LSB-1:SLOT_LSB];

  always_comb begin
    tgt = TGT_NONE;
    if (in_ram) begin
      tgt = TGT_RAM;
    end else if (in_win) begin
      if (slot == INTC_SLOT_A || slot == INTC_SLOT_B) tgt = TGT_INTC;
      else if (slot == UART_SLOT)                     tgt = TGT_UART;
      else if (slot == BLK_SLOT)                      tgt = TGT_BLK;
    end
  end
endmodule

// File: rtl/mmdec_irq_merge.sv
module mmdec_irq_merge #(
  parameter int unsigned SRC_W    = 8,
  parameter int unsigned UART_BIT = 1,
  parameter int unsigned BLK_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uart_touch,
  input  logic             blk_touch,
  input  logic             intc_touch,
  input  logic             uart_lvl,
  input  logic             blk_lvl,
  output logic [SRC_W-1:0] src,
  output logic             eval
);
  logic uart_q;
  logic blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          uart_q <= 1'b0;
    else if (uart_touch) uart_q <= uart_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blk_q <= 1'b0;
    else if (blk_touch) blk_q <= blk_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval <= 1'b0;
    else        eval <= uart_touch | blk_touch | intc_touch;
  end

  for (genvar b = 0; b < SRC_W; b++) begin : g_src
    if (b == UART_BIT) begin : g_uart
      assign src[b] = uart_q;
    end else if (b == BLK_BIT) begin : g_blk
      assign src[b] = blk_q;
    end else begin : g_idle
      assign src[b] = 1'b0;
    end
  end

  // R8: serial bit moves only on a serial access, and then to the sampled level
  a_r8_uart_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_touch |=> $stable(src[UART_BIT]));
  a_r8_uart_take: assert property (@(posedge clk) disable iff (!rst_n)
    uart_touch |=> (src[UART_BIT] == $past(uart_lvl)));
  // R9: block bit likewise
  a_r9_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_touch |=> $stable(src[BLK_BIT]));
  a_r9_blk_take: assert property (@(posedge clk) disable iff (!rst_n)
    blk_touch |=> (src[BLK_BIT] == $past(blk_lvl)));
endmodule

// File: rtl/mmdec_resp.sv
module mmdec_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic              err_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rdata_in;
      rsp_err   <= err_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7: stalled response is frozen
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  // R4: an error response never carries data
  a_r4_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

// File: rtl/mem_io_router.sv
module mem_io_router
  import mmdec_pkg::*;
#(
  parameter int unsigned     DATA_W     = 32,
  parameter logic [ADDR_W:0] RAM_BYTES  = 33'h0_0400_0000,
  parameter int unsigned     INTC_OFF_W = 26,
  parameter int unsigned     DEV_OFF_W  = 20,
  parameter int unsigned     SRC_W      = 8,
  parameter int unsigned     UART_SRC   = 1,
  parameter int unsigned     BLK_SRC    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_err,
  output logic                  wr_en,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  ram_sel,
  output logic [ADDR_W-1:0]     ram_addr,
  input  logic [DATA_W-1:0]     ram_rdata,
  output logic                  intc_sel,
  output logic [INTC_OFF_W-1:0] intc_off,
  input  logic [DATA_W-1:0]     intc_rdata,
  output logic [SRC_W-1:0]      intc_src,
  output logic                  intc_eval,
  output logic                  uart_sel,
  output logic [DEV_OFF_W-1:0]  uart_off,
  input  logic [DATA_W-1:0]     uart_rdata,
  input  logic                  uart_irq,
  output logic                  blk_sel,
  output logic [DEV_OFF_W-1:0]  blk_off,
  input  logic [DATA_W-1:0]     blk_rdata,
  input  logic                  blk_irq
);
  tgt_e              tgt;
  logic              accept;
  logic [N_TGT-1:0]  hit;
  logic [DATA_W-1:0] rd_mux;

  mmdec_slot_decode #(
    .RAM_BYTES (RAM_BYTES)
  ) u_decode (
    .addr (req_addr),
    .tgt  (tgt)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar t = 0; t < N_TGT; t++) begin : g_hit
    assign hit[t] = accept && (tgt == tgt_e'(t));
  end

  assign ram_sel  = hit[TGT_RAM];
  assign intc_sel = hit[TGT_INTC];
  assign uart_sel = hit[TGT_UART];
  assign blk_sel  = hit[TGT_BLK];

  assign ram_addr = req_addr;
  assign intc_off = req_addr[INTC_OFF_W-1:0];
  assign uart_off = req_addr[DEV_OFF_W-1:0];
  assign blk_off  = req_addr[DEV_OFF_W-1:0];
  assign wr_en    = req_write;
  assign wr_data  = req_wdata;

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      unique case (tgt)
        TGT_RAM:  rd_mux = ram_rdata;
        TGT_INTC: rd_mux = intc_rdata;
        TGT_UART: rd_mux = uart_rdata;
        TGT_BLK:  rd_mux = blk_rdata;
        default:  rd_mux = '0;
      endcase
    end
  end

  mmdec_resp #(
    .DATA_W (DATA_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rdata_in  (rd_mux),
    .err_in    (hit[TGT_NONE]),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  mmdec_irq_merge #(
    .SRC_W    (SRC_W),
    .UART_BIT (UART_SRC),
    .BLK_BIT  (BLK_SRC)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .uart_touch (uart_sel),
    .blk_touch  (blk_sel),
    .intc_touch (intc_sel),
    .uart_lvl   (uart_irq),
    .blk_lvl    (blk_irq),
    .src        (intc_src),
    .eval       (intc_eval)
  );

  // R5: one strobe at most, and only in an accepting cycle
  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, intc_sel, uart_sel, blk_sel}));
  a_r5_select_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel || intc_sel || uart_sel || blk_sel) |-> (req_valid && req_ready));
  // R6: acceptance is answered in the next cycle
  a_r6_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R10: evaluate pulse tracks peripheral strobes only
  a_r10_eval_after_io: assert property (@(posedge clk) disable iff (!rst_n)
    (intc_sel || uart_sel || blk_sel) |=> intc_eval);
  a_r10_no_eval_else: assert property (@(posedge clk) disable iff (!rst_n)
    !(intc_sel || uart_sel || blk_sel) |=> !intc_eval);
endmodule

// File: tb/mem_io_router_bench.sv
module mem_io_router_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;
  localparam logic [31:0] RAM_TOP = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        uart_irq = 1'b0, blk_irq = 1'b0;
  logic        req_ready, rsp_valid, rsp_err, wr_en;
  logic [31:0] rsp_rdata, wr_data, ram_addr, ram_rdata, intc_rdata, uart_rdata, blk_rdata;
  logic        ram_sel, intc_sel, uart_sel, blk_sel, intc_eval;
  logic [25:0] intc_off;
  logic [19:0] uart_off, blk_off;
  logic [7:0]  intc_src;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_io_router u_mem_io_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .wr_en(wr_en), .wr_data(wr_data),
    .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .intc_sel(intc_sel), .intc_off(intc_off), .intc_rdata(intc_rdata),
    .intc_src(intc_src), .intc_eval(intc_eval),
    .uart_sel(uart_sel), .uart_off(uart_off), .uart_rdata(uart_rdata), .uart_irq(uart_irq),
    .blk_sel(blk_sel), .blk_off(blk_off), .blk_rdata(blk_rdata), .blk_irq(blk_irq)
  );

  // ---------------- target stubs: small register files ----------------
  logic [31:0] s_mem [1:4][0:15];
  initial for (int t = 1; t <= 4; t++) for (int i = 0; i < 16; i++) s_mem[t][i] = '0;

  assign ram_rdata  = s_mem[1][ram_addr[5:2]] ^ ram_addr;
  assign intc_rdata = s_mem[2][intc_off[5:2]] ^ {6'd0, intc_off};
  assign uart_rdata = s_mem[3][uart_off[5:2]] ^ {12'd0, uart_off};
  assign blk_rdata  = s_mem[4][blk_off[5:2]]  ^ {12'd0, blk_off};

  always @(posedge clk) begin
    if (wr_en) begin
      if (ram_sel)  s_mem[1][ram_addr[5:2]] <= wr_data;
      if (intc_sel) s_mem[2][intc_off[5:2]] <= wr_data;
      if (uart_sel) s_mem[3][uart_off[5:2]] <= wr_data;
      if (blk_sel)  s_mem[4][blk_off[5:2]]  <= wr_data;
    end
  end

  // ---------------- reference model ----------------
  function automatic int ref_tgt(logic [31:0] a);
    if (a < RAM_TOP) return 1;
    if (a[31:28] != 4'hF) return 0;
    case (a[27:20])
      8'h00, 8'h02: return 2;
      8'h40:        return 3;
      8'h42:        return 4;
      default:      return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_off(logic [31:0] a, int t);
    if (t == 1) return a;
    if (t == 2) return a & 32'h03FF_FFFF;
    return a & 32'h000F_FFFF;
  endfunction

  logic [31:0] r_mem [1:4][0:15];
  initial for (int t = 1; t <= 4; t++) for (int i = 0; i < 16; i++) r_mem[t][i] = '0;
  logic        m_rv = 1'b0, m_err = 1'b0, m_eval = 1'b0;
  logic [31:0] m_rd = '0;
  logic [7:0]  m_src = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_rv <= 1'b0; m_err <= 1'b0; m_eval <= 1'b0; m_rd <= '0; m_src <= '0;
    end else if (req_valid && (!m_rv || rsp_ready)) begin
      automatic int t = ref_tgt(req_addr);
      automatic logic [31:0] o = ref_off(req_addr, t);
      m_rv   <= 1'b1;
      m_err  <= (t == 0);
      m_rd   <= (req_write || t == 0) ? 32'd0 : (r_mem[t][o[5:2]] ^ o);
      if (req_write && t != 0) r_mem[t][o[5:2]] <= req_wdata;
      m_eval <= (t >= 2);
      if (t == 3) m_src[1] <= uart_irq;
      if (t == 4) m_src[2] <= blk_irq;
    end else begin
      if (rsp_ready) m_rv <= 1'b0;
      m_eval <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit rdy = !m_rv || rsp_ready;
      automatic bit acc = req_valid && rdy;
      automatic int t = ref_tgt(req_addr);
      automatic logic [31:0] o = ref_off(req_addr, t);
      chk(req_ready == rdy, "R5 req_ready", {31'd0, req_ready}, {31'd0, rdy});
      chk(ram_sel == (acc && t == 1), "R1 ram_sel", {31'd0, ram_sel}, {31'd0, acc && t == 1});
      chk(intc_sel == (acc && t == 2), "R2 intc_sel", {31'd0, intc_sel}, {31'd0, acc && t == 2});
      chk(uart_sel == (acc && t == 3), "R3 uart_sel", {31'd0, uart_sel}, {31'd0, acc && t == 3});
      chk(blk_sel == (acc && t == 4), "R3 blk_sel", {31'd0, blk_sel}, {31'd0, acc && t == 4});
      if (acc && t == 1) chk(ram_addr == o, "R1 ram_addr", ram_addr, o);
      if (acc && t == 2) chk({6'd0, intc_off} == o, "R2 intc_off", {6'd0, intc_off}, o);
      if (acc && t == 3) chk({12'd0, uart_off} == o, "R3 uart_off", {12'd0, uart_off}, o);
      if (acc && t == 4) chk({12'd0, blk_off} == o, "R3 blk_off", {12'd0, blk_off}, o);
      chk(rsp_valid == m_rv, "R6/R7 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
      if (m_rv) begin
        chk(rsp_rdata == m_rd, "R6 rsp_rdata", rsp_rdata, m_rd);
        chk(rsp_err == m_err, "R4 rsp_err", {31'd0, rsp_err}, {31'd0, m_err});
      end
      chk(intc_src == m_src, "R8/R9 intc_src", {24'd0, intc_src}, {24'd0, m_src});
      chk(intc_eval == m_eval, "R10 intc_eval", {31'd0, intc_eval}, {31'd0, m_eval});
    end
  end

  // response back-pressure driver
  initial forever begin
    @(posedge clk); #1;
    if (bp_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rsp_ready = lfsr[0] | lfsr[3];
    end else begin
      rsp_ready = 1'b1;
    end
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d);
    bit rdy;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); rdy = req_ready;
      @(posedge clk);
    end while (!rdy);
    #1 req_valid = 1'b0;
  endtask

  logic [31:0] addr_set [0:11];
  initial begin
    addr_set[0] = 32'h0000_0000; addr_set[1] = 32'h03FF_FFFC; addr_set[2] = 32'h0400_0000;
    addr_set[3] = 32'hF000_0008; addr_set[4] = 32'hF020_0008; addr_set[5] = 32'hF010_0000;
    addr_set[6] = 32'hF400_0004; addr_set[7] = 32'hF420_000C; addr_set[8] = 32'hF410_0000;
    addr_set[9] = 32'hFFF0_0000; addr_set[10] = 32'hE000_0000; addr_set[11] = 32'hF42F_FFF0;
  end

  // watchdog
  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk(rsp_valid == 1'b0, "R11 rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
    chk(intc_src == 8'd0, "R11 intc_src at reset", {24'd0, intc_src}, 32'd0);
    chk(intc_eval == 1'b0, "R11 intc_eval at reset", {31'd0, intc_eval}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 R2 R3 R4: stores to every decode class, boundaries included
    for (int i = 0; i < 12; i++) access(1'b1, addr_set[i], 32'h1000_0000 + 32'(i) * 32'h0101_0101);
    // R6: loads back
    for (int i = 0; i < 12; i++) access(1'b0, addr_set[i], 32'd0);

    // R8 R9: source bits follow device accesses only
    uart_irq = 1'b1; blk_irq = 1'b1;
    access(1'b0, 32'h0000_0040, 0);   // RAM: no change
    access(1'b0, 32'hF000_0000, 0);   // controller: no change, eval pulse
    access(1'b0, 32'hF400_0000, 0);   // serial: bit 1 set
    access(1'b1, 32'hF420_0000, 32'h55); // block: bit 2 set
    uart_irq = 1'b0;
    access(1'b0, 32'hF420_0004, 0);   // bit 1 must hold
    access(1'b0, 32'hF400_0008, 0);   // bit 1 clears
    blk_irq = 1'b0;
    access(1'b0, 32'hF010_0000, 0);   // error: bit 2 holds
    access(1'b0, 32'hF420_0008, 0);   // bit 2 clears
    repeat (2) @(posedge clk); #1;

    // R5 R7: back-pressure with interrupt levels changing while requests wait
    bp_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      automatic int k = (i * 7 + int'(lfsr[3:0])) % 12;
      uart_irq = lfsr[5];
      blk_irq  = lfsr[9];
      fork
        access(lfsr[2], addr_set[k] + {26'd0, lfsr[7:4], 2'b00}, {lfsr, ~lfsr});
        begin #(CLK_PERIOD/2 + 1); uart_irq = ~uart_irq; blk_irq = lfsr[11]; end
      join
    end
    bp_mode = 1'b0;
    repeat (5) @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R7 response drained", {31'd0, rsp_valid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule